// File: doc/BRIEF.md
# Operand Addressing Byte Decoder and Effective Address Generator

This block turns the addressing byte of a 16-bit instruction, together with the displacement bytes that follow it, into a resolved operand location. A pulse on `start` hands over the addressing byte, the operand width bit and an optional segment override prefix. The block then waits for the zero, one or two displacement bytes that the mode field calls for. Each byte is offered on a valid strobe, and any number of idle cycles may come between bytes. When the last byte has been accepted, `done` pulses for one cycle.

While `done` is high the outputs state whether the operand is a register or a memory location. For a register operand, the block gives a 4-bit code formed from the width bit and the r/m field. For a memory operand, it gives the 16-bit effective offset, the selected segment and the 20-bit physical address. The base, pointer, index and segment register values come in as live inputs and must be held steady until `done`. Opcode decoding and the register file are outside this block.

Top module: `modrm_ea_gen`

## Requirements
- R1: The addressing byte splits into mode = bits 7:6, reg = bits 5:3 and r/m = bits 2:0. `reg_field` carries bits 5:3 of the byte that was accepted. `is_reg` is 1 exactly when mode is 11.
- R2: For mode 11, `done` is high in the cycle after `start` is accepted and no displacement byte is taken. `rm_reg_code` = {wide, r/m}, where r/m 0..7 means AL,CL,DL,BL,AH,CH,DH,BH with wide=0 and AX,CX,DX,BX,SP,BP,SI,DI with wide=1.
- R3: For mode 00 with r/m not equal to 110, `done` is high in the cycle after `start`. `ea` is the base sum selected by r/m: 000 BX+SI, 001 BX+DI, 010 BP+SI, 011 BP+DI, 100 SI, 101 DI, 111 BX.
- R4: For mode 01, exactly one displacement byte is taken. It is sign-extended and added to the base sum, where r/m 110 means BP. `done` is high in the cycle after that byte is accepted.
- R5: For mode 10, two displacement bytes are taken, low byte first, and form a 16-bit displacement that is added to the base sum. `done` follows the second byte by one cycle.
- R6: Mode 00 with r/m 110 takes two bytes, low first, and uses them as the offset directly. BP is not used, and the default segment is DS.
- R7: `seg_sel` encodes ES=0, CS=1, SS=2, DS=3. Without an override, the forms that use BP select SS (r/m 010, 011, and r/m 110 in modes 01/10). All other memory forms select DS.
- R8: When `pfx_valid` is high at `start` and `pfx_byte` has the pattern 001rr110, the segment becomes rr. A prefix byte that lacks this pattern is ignored.
- R9: `ea` wraps modulo 2^16, and `phys` = segment value × 16 + `ea`, modulo 2^20.
- R10: A `start` pulse while `busy` is high is ignored. `disp_valid` while idle is ignored. No byte is taken while `disp_valid` is low.
- R11: After reset, `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a new addressing byte |
| modrm | input | 8 | Addressing byte |
| wide | input | 1 | Operand width bit (1 = 16-bit) |
| pfx_valid | input | 1 | A prefix byte accompanies start |
| pfx_byte | input | 8 | Candidate segment override prefix |
| disp_valid | input | 1 | Displacement byte offered |
| disp_byte | input | 8 | Displacement byte |
| bx_val | input | 16 | Base register value |
| bp_val | input | 16 | Base pointer value |
| si_val | input | 16 | Source index value |
| di_val | input | 16 | Destination index value |
| es_val | input | 16 | Extra segment value |
| cs_val | input | 16 | Code segment value |
| ss_val | input | 16 | Stack segment value |
| ds_val | input | 16 | Data segment value |
| busy | output | 1 | Waiting for displacement bytes |
| done | output | 1 | One-cycle result strobe |
| is_reg | output | 1 | Operand is a register |
| reg_field | output | 3 | Reg field of the addressing byte |
| rm_reg_code | output | 4 | {wide, r/m} register code |
| ea | output | 16 | Effective offset |
| seg_sel | output | 2 | Selected segment code |
| phys | output | 20 | Physical address |

## Verification
The bench targets the table's traps: mode 00 with r/m 110 must read two bytes and ignore BP, while r/m 110 in modes 01/10 must use BP and SS. A design that got this wrong would either stall waiting for bytes that never come, or run ahead into the next instruction. Negative 8-bit displacements and offset sums near 0xFFFF expose a missing sign extension or a carry leaking into the physical address. Prefix bytes that nearly match the override pattern catch decoders that ignore the fixed bits. Gaps between displacement bytes, a stray start while busy, and a stray byte while idle catch a sequencer that counts cycles instead of accepted bytes.

// File: rtl/modrm_ea_gen.sv
module modrm_ea_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  modrm,
  input  logic        wide,
  input  logic        pfx_valid,
  input  logic [7:0]  pfx_byte,
  input  logic        disp_valid,
  input  logic [7:0]  disp_byte,
  input  logic [15:0] bx_val,
  input  logic [15:0] bp_val,
  input  logic [15:0] si_val,
  input  logic [15:0] di_val,
  input  logic [15:0] es_val,
  input  logic [15:0] cs_val,
  input  logic [15:0] ss_val,
  input  logic [15:0] ds_val,
  output logic        busy,
  output logic        done,
  output logic        is_reg,
  output logic [2:0]  reg_field,
  output logic [3:0]  rm_reg_code,
  output logic [15:0] ea,
  output logic [1:0]  seg_sel,
  output logic [19:0] phys
);
  logic [1:0]  mod_q, ovr_sel_q, idx_q, need_q, need_in;
  logic [2:0]  reg_q, rm_q;
  logic        w_q, ovr_q, busy_q, done_q, direct;
  logic [7:0]  lo_q, hi_q;
  logic [15:0] base, disp, segv;

  always_comb begin
    if (modrm[7:6] == 2'b01) need_in = 2'd1;
    else if (modrm[7:6] == 2'b10 || (modrm[7:6] == 2'b00 && modrm[2:0] == 3'b110)) need_in = 2'd2;
    else need_in = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '0; reg_q <= '0; rm_q <= '0; w_q <= 1'b0;
      ovr_q <= 1'b0; ovr_sel_q <= '0; idx_q <= '0; need_q <= '0;
      lo_q <= '0; hi_q <= '0; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        mod_q     <= modrm[7:6];
        reg_q     <= modrm[5:3];
        rm_q      <= modrm[2:0];
        w_q       <= wide;
        ovr_q     <= pfx_valid && pfx_byte[7:5] == 3'b001 && pfx_byte[2:0] == 3'b110;
        ovr_sel_q <= pfx_byte[4:3];
        need_q    <= need_in;
        idx_q     <= '0;
        lo_q      <= '0;
        hi_q      <= '0;
        busy_q    <= need_in != 2'd0;
        done_q    <= need_in == 2'd0;
      end else if (busy_q && disp_valid) begin
        if (idx_q == 2'd0) lo_q <= disp_byte;
        else hi_q <= disp_byte;
        idx_q <= idx_q + 2'd1;
        if (idx_q + 2'd1 == need_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign direct = mod_q == 2'b00 && rm_q == 3'b110;

  always_comb begin
    case (rm_q)
      3'd0: base = bx_val + si_val;
      3'd1: base = bx_val + di_val;
      3'd2: base = bp_val + si_val;
      3'd3: base = bp_val + di_val;
      3'd4: base = si_val;
      3'd5: base = di_val;
      3'd6: base = bp_val;
      default: base = bx_val;
    endcase
    case (mod_q)
      2'b01:   disp = {{8{lo_q[7]}}, lo_q};
      2'b10:   disp = {hi_q, lo_q};
      default: disp = 16'h0000;
    endcase
  end

  assign ea = direct ? {hi_q, lo_q} : base + disp;

  always_comb begin
    if (ovr_q) seg_sel = ovr_sel_q;
    else if (!direct && (rm_q == 3'd2 || rm_q == 3'd3 || rm_q == 3'd6)) seg_sel = 2'd2;
    else seg_sel = 2'd3;
    case (seg_sel)
      2'd0: segv = es_val;
      2'd1: segv = cs_val;
      2'd2: segv = ss_val;
      default: segv = ds_val;
    endcase
  end

  assign phys        = {segv, 4'h0} + {4'h0, ea};
  assign busy        = busy_q;
  assign done        = done_q;
  assign is_reg      = mod_q == 2'b11;
  assign reg_field   = reg_q;
  assign rm_reg_code = {w_q, rm_q};
endmodule

// File: rtl/modrm_ea_chk.sv
module modrm_ea_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] modrm,
  input logic       pfx_valid,
  input logic [7:0] pfx_byte,
  input logic       disp_valid,
  input logic       busy,
  input logic       done,
  input logic       is_reg,
  input logic [1:0] seg_sel
);
  p_reg_form_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && modrm[7:6] == 2'b11 |=> done && is_reg && !busy);

  p_one_byte_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && modrm[7:6] == 2'b01 |=> busy && !done);

  p_direct_ds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !pfx_valid && modrm[7:6] == 2'b00 && modrm[2:0] == 3'b110
    |=> busy && seg_sel == 2'd3);

  p_override_es_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && pfx_valid && pfx_byte == 8'h26 |=> seg_sel == 2'd0);

  p_hold_no_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !disp_valid |=> busy && !done);

  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind modrm_ea_gen modrm_ea_chk u_chk (.*);

// File: tb/sim_modrm_ea_gen.sv
module sim_modrm_ea_gen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, wide = 0, pfx_valid = 0, disp_valid = 0;
  logic [7:0] modrm = 0, pfx_byte = 0, disp_byte = 0;
  logic [15:0] bx_val = 0, bp_val = 0, si_val = 0, di_val = 0;
  logic [15:0] es_val = 0, cs_val = 0, ss_val = 0, ds_val = 0;
  logic busy, done, is_reg;
  logic [2:0] reg_field;
  logic [3:0] rm_reg_code;
  logic [15:0] ea;
  logic [1:0] seg_sel;
  logic [19:0] phys;

  int n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modrm_ea_gen u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int need_of(input logic [7:0] m);
    if (m[7:6] == 2'b01) return 1;
    if (m[7:6] == 2'b10 || (m[7:6] == 2'b00 && m[2:0] == 3'b110)) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] exp_ea(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] b, d;
    if (m[7:6] == 2'b00 && m[2:0] == 3'b110) return {hi, lo};
    case (m[2:0])
      0: b = bx_val + si_val;  1: b = bx_val + di_val;
      2: b = bp_val + si_val;  3: b = bp_val + di_val;
      4: b = si_val;           5: b = di_val;
      6: b = bp_val;           default: b = bx_val;
    endcase
    d = (m[7:6] == 2'b01) ? {{8{lo[7]}}, lo} : (m[7:6] == 2'b10) ? {hi, lo} : 16'h0;
    return b + d;
  endfunction

  function automatic logic [1:0] exp_seg(input logic [7:0] m, input bit pv, input logic [7:0] pb);
    if (pv && pb[7:5] == 3'b001 && pb[2:0] == 3'b110) return pb[4:3];
    if (!(m[7:6] == 2'b00 && m[2:0] == 3'b110) && (m[2:0] == 2 || m[2:0] == 3 || m[2:0] == 6)) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [15:0] seg_value(input logic [1:0] s);
    case (s) 0: return es_val; 1: return cs_val; 2: return ss_val; default: return ds_val; endcase
  endfunction

  task automatic run_case(input logic [7:0] m, input bit w, input bit pv, input logic [7:0] pb,
                          input logic [7:0] lo, input logic [7:0] hi, input int gap, input bit poke);
    int n;
    logic [15:0] e;
    logic [1:0] s;
    logic [19:0] p;
    n = need_of(m);
    @(negedge clk);
    start = 1; modrm = m; wide = w; pfx_valid = pv; pfx_byte = pb;
    @(negedge clk);
    start = 0; pfx_valid = 0;
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        if (poke) begin start = 1; modrm = 8'hC0; end
        @(negedge clk);
        start = 0;
        check(busy && !done, "R10 waiting", {30'd0, busy, done}, 32'd2);
      end
      disp_valid = 1; disp_byte = (i == 0) ? lo : hi;
      @(negedge clk);
      disp_valid = 0;
    end
    e = exp_ea(m, lo, hi);
    s = (m[7:6] == 2'b11) ? seg_sel : exp_seg(m, pv, pb);
    p = {seg_value(s), 4'h0} + {4'h0, e};
    check(done && !busy, "R2/R4/R5 done strobe", {30'd0, done, busy}, 32'd2);
    check(is_reg == (m[7:6] == 2'b11), "R1 is_reg", is_reg, m[7:6] == 2'b11);
    check(reg_field == m[5:3], "R1 reg_field", reg_field, m[5:3]);
    if (m[7:6] == 2'b11)
      check(rm_reg_code == {w, m[2:0]}, "R2 reg code", rm_reg_code, {w, m[2:0]});
    else begin
      check(ea == e, (m[7:6] == 2'b00) ? ((m[2:0] == 6) ? "R6 direct ea" : "R3 ea") :
                     (m[7:6] == 2'b01) ? "R4 ea" : "R5 ea", ea, e);
      check(seg_sel == s, pv ? "R8 seg" : "R7 seg", seg_sel, s);
      check(phys == p, "R9 phys", phys, p);
    end
    @(negedge clk);
    check(!done, "R2 done one cycle", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    bx_val = 16'h1000; bp_val = 16'h2000; si_val = 16'h0030; di_val = 16'h0400;
    es_val = 16'h1111; cs_val = 16'h2222; ss_val = 16'h3333; ds_val = 16'h4444;
    #(CLK_PERIOD*2 + 1);
    check(!busy && !done, "R11 reset", {30'd0, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    disp_valid = 1; disp_byte = 8'h55;
    @(negedge clk);
    disp_valid = 0;
    check(!busy && !done, "R10 stray byte idle", {30'd0, busy, done}, 0);
    run_case(8'hC5, 1'b0, 0, 0, 0, 0, 0, 0);        // R2 CH
    run_case(8'hDF, 1'b1, 0, 0, 0, 0, 0, 0);        // R2 DI
    run_case(8'h02, 1'b1, 0, 0, 0, 0, 0, 0);        // R3 BP+SI, SS
    run_case(8'h07, 1'b1, 0, 0, 0, 0, 0, 0);        // R3 BX, DS
    run_case(8'h06, 1'b1, 0, 0, 8'h34, 8'h12, 2, 1); // R6 direct, R10 poke
    run_case(8'h46, 1'b1, 0, 0, 8'hF0, 0, 1, 0);    // R4 BP-16, SS
    run_case(8'h86, 1'b1, 0, 0, 8'h00, 8'h80, 0, 0); // R5 BP+disp16
    run_case(8'h06, 1'b0, 1, 8'h2E, 8'hFF, 8'hFF, 0, 0); // R8 CS on direct
    run_case(8'h42, 1'b0, 1, 8'h27, 8'h01, 0, 0, 0); // R8 near-miss ignored
    run_case(8'h03, 1'b0, 1, 8'h26, 0, 0, 0, 0);    // R8 ES over SS
    bx_val = 16'hFFF0; si_val = 16'h0020; ds_val = 16'hFFFF;
    run_case(8'h80, 1'b0, 0, 0, 8'hF0, 8'hFF, 0, 0); // R9 wrap
    for (int k = 0; k < 250; k++) begin
      logic [7:0] m, pb;
      bit pv;
      bx_val = 16'($urandom); bp_val = 16'($urandom); si_val = 16'($urandom); di_val = 16'($urandom);
      es_val = 16'($urandom); cs_val = 16'($urandom); ss_val = 16'($urandom); ds_val = 16'($urandom);
      m = 8'($urandom);
      pv = 1'($urandom);
      pb = ($urandom % 2) ? {3'b001, 2'($urandom), 3'b110} : 8'($urandom);
      run_case(m, 1'($urandom), pv, pb, 8'($urandom), 8'($urandom), int'($urandom % 3), 1'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule